// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller with Initialization Sequencer

The block is a single eight-input interrupt controller with a byte-wide register port. Software programs it through two addresses, the even port and the odd port, which `addr_odd` selects. A fixed sequence of four initialization words sets it up. The first word sets the trigger mode and restarts setup. The second gives the upper five vector bits. The third is a cascade value that is only stored. The fourth selects automatic or normal end-of-interrupt. Once setup is finished, odd-port writes load the mask register, and odd-port reads return it.

Requests pass through a synchronizer. In edge mode a request is latched on a rising edge. In level mode the pending bit follows the input level. Line 0 has the highest priority and line 7 the lowest. `int_out` is raised when an unmasked pending request outranks every line in service. A one-cycle `inta` pulse moves the winner into service and registers an 8-bit vector. In normal mode, an even-port write with bit 5 set and bit 4 clear retires the highest-priority line in service.

The sequencer has five named states. WAIT_ICW1 is the reset state. ICW2, ICW3 and ICW4 each wait for an odd-port write. READY is normal operation. The transitions are as follows. Any state goes to ICW2 on an even-port write with bit 4 set. ICW2 goes to ICW3, ICW3 goes to ICW4, and ICW4 goes to READY, each on an odd-port write. Every other access leaves the state unchanged.

Top module: `irqc_core`

## Requirements
- R1: After reset `int_out` is 0, `vec_out` is 00h and an odd-port read returns FFh (all lines masked).
- R2: An even-port write with bit 4 = 1 clears the mask to 00h and restarts setup. The next three odd-port writes become the second, third and fourth initialization words in that order, and none of them reaches the mask.
- R3: In READY an odd-port write loads the mask, and an odd-port read returns it. Mask bit n set to 1 blocks line n. Clearing that bit lets a held pending request raise `int_out` on the next edge.
- R4: With first-word bit 3 = 0 (edge mode), a rising input makes `int_out` rise on the third clock edge. Acknowledge clears the pending bit, and an input held high does not request again.
- R5: With first-word bit 3 = 1 (level mode), `int_out` rises on the second clock edge after the input rises. The pending bit clears once the input is low.
- R6: On acknowledge the vector is {second word bits 7:3, winning line number in 3 bits}, with line 0 winning over all others. Bits 2:0 of the second word are ignored.
- R7: `int_out` is raised only when the best unmasked pending line has a smaller number than the best line in service.
- R8: In normal mode (fourth-word bit 1 = 0), an even-port write with bit 4 = 0 and bit 5 = 1 clears the in-service bit of the lowest-numbered line.
- R9: With fourth-word bit 1 = 1 (automatic mode), acknowledge leaves no line in service, so a lower-priority request is raised right after it.
- R10: An acknowledge while `int_out` is 0 returns the vector {second word bits 7:3, 111b} and changes no state.
- R11: Until setup completes, `int_out` stays 0. In WAIT_ICW1 odd-port writes are ignored.
- R12: First-word bit 2, the third word and fourth-word bit 4 are stored and change no output. In particular, the vector does not depend on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_odd | input | 1 | Port select: 0 even, 1 odd |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Mask value on an odd-port read, 00h otherwise (combinational) |
| irq_in | input | 8 | Asynchronous request lines, line 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle |
| vec_out | output | 8 | Vector registered at the acknowledge edge |

## Verification
Register writes and acknowledges take effect at the clock edge that samples the strobe. A level-mode request reaches `int_out` at the second edge after the input changes, and an edge-mode request reaches it at the third edge. The bench drives all inputs on falling edges and samples on falling edges. Each check is therefore placed after an exact number of edges. Checks that one edge too early shows no request confirm that the latency is neither short nor long. Mask reads are combinational and are sampled inside the same low phase.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_ICW1,
        ST_ICW2,
        ST_ICW3,
        ST_ICW4,
        ST_READY
    } init_st_t;

    localparam int SEL_INIT_BIT = 4;  // even-port: start of setup
    localparam int SEL_EOI_BIT  = 5;  // even-port: end-of-interrupt command
    localparam int TRIG_BIT     = 3;  // first word: 1 = level
    localparam int SPACING_BIT  = 2;  // first word: stored only
    localparam int AUTO_BIT     = 1;  // fourth word: automatic EOI
    localparam int NEST_BIT     = 4;  // fourth word: stored only
endpackage

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W),
    localparam int BASE_W = W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_odd,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output init_st_t          state,
    output logic              init_stb,
    output logic              eoi_stb,
    output logic              level_mode,
    output logic              spacing4,
    output logic              nest_en,
    output logic              auto_eoi,
    output logic [BASE_W-1:0] base_hi,
    output logic [W-1:0]      cascade_cfg,
    output logic [W-1:0]      mask
);
    init_st_t nxt;
    logic     odd_wr;

    assign odd_wr   = wr_en && addr_odd;
    assign init_stb = wr_en && !addr_odd && wr_data[SEL_INIT_BIT];
    assign eoi_stb  = wr_en && !addr_odd && !wr_data[SEL_INIT_BIT] &&
                      wr_data[SEL_EOI_BIT] && (state == ST_READY) && !auto_eoi;

    always_comb begin
        nxt = state;
        if (init_stb) begin
            nxt = ST_ICW2;
        end else if (odd_wr) begin
            unique case (state)
                ST_ICW2: nxt = ST_ICW3;
                ST_ICW3: nxt = ST_ICW4;
                ST_ICW4: nxt = ST_READY;
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_ICW1;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            spacing4    <= 1'b0;
            nest_en     <= 1'b0;
            auto_eoi    <= 1'b0;
            base_hi     <= '0;
            cascade_cfg <= '0;
            mask        <= '1;
        end else if (init_stb) begin
            level_mode <= wr_data[TRIG_BIT];
            spacing4   <= wr_data[SPACING_BIT];
            auto_eoi   <= 1'b0;
            mask       <= '0;
        end else if (odd_wr) begin
            unique case (state)
                ST_ICW2:  base_hi <= wr_data[W-1:IDX_W];
                ST_ICW3:  cascade_cfg <= wr_data;
                ST_ICW4: begin
                    auto_eoi <= wr_data[AUTO_BIT];
                    nest_en  <= wr_data[NEST_BIT];
                end
                ST_READY: mask <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] irq_in,
    input  logic         level_mode,
    input  logic         init_stb,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] sync_a, sync_b, sync_c, edge_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_a[i] <= 1'b0;
                sync_b[i] <= 1'b0;
                sync_c[i] <= 1'b0;
                edge_q[i] <= 1'b0;
            end else begin
                sync_a[i] <= irq_in[i];
                sync_b[i] <= sync_a[i];
                sync_c[i] <= sync_b[i];
                if (init_stb)
                    edge_q[i] <= 1'b0;
                else if (sync_b[i] && !sync_c[i])
                    edge_q[i] <= 1'b1;
                else if (ack_clr[i])
                    edge_q[i] <= 1'b0;
            end
        end
        assign pend[i] = level_mode ? sync_b[i] : edge_q[i];
    end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W),
    localparam int BASE_W = W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [W-1:0]      pend,
    input  logic [W-1:0]      mask,
    input  logic              inta,
    input  logic              eoi_stb,
    input  logic              init_stb,
    input  logic              auto_eoi,
    input  logic [BASE_W-1:0] base_hi,
    output logic              int_out,
    output logic [W-1:0]      vec_out,
    output logic [W-1:0]      ack_clr,
    output logic [W-1:0]      isr
);
    logic [W-1:0]     req_m, isr_n;
    logic [IDX_W-1:0] win_idx, isr_idx;
    logic             win_any, isr_any, take;

    function automatic logic [IDX_W:0] first_set(input logic [W-1:0] v);
        logic [IDX_W:0] r;
        r = '0;
        for (int i = W - 1; i >= 0; i--)
            if (v[i]) r = {1'b1, IDX_W'(i)};
        return r;
    endfunction

    assign req_m              = pend & ~mask;
    assign {win_any, win_idx} = first_set(req_m);
    assign {isr_any, isr_idx} = first_set(isr);
    assign int_out = ready && win_any && (!isr_any || (win_idx < isr_idx));
    assign take    = inta && int_out;
    assign ack_clr = take ? (W'(1) << win_idx) : '0;

    always_comb begin
        isr_n = isr;
        if (eoi_stb && isr_any) isr_n[isr_idx] = 1'b0;
        if (take && !auto_eoi)  isr_n[win_idx] = 1'b1;
        if (init_stb)           isr_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            vec_out <= '0;
        end else begin
            isr <= isr_n;
            if (inta)
                vec_out <= take ? {base_hi, win_idx} : {base_hi, {IDX_W{1'b1}}};
        end
    end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W),
    localparam int BASE_W = W - IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         addr_odd,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] irq_in,
    output logic         int_out,
    input  logic         inta,
    output logic [W-1:0] vec_out
);
    init_st_t          st_w;
    logic              init_stb, eoi_stb, level_mode, spacing4, nest_en, auto_eoi;
    logic [BASE_W-1:0] base_hi;
    logic [W-1:0]      cascade_cfg, mask, pend, ack_clr, isr;

    irqc_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr_odd(addr_odd), .wr_en(wr_en),
        .wr_data(wr_data), .state(st_w), .init_stb(init_stb), .eoi_stb(eoi_stb),
        .level_mode(level_mode), .spacing4(spacing4), .nest_en(nest_en),
        .auto_eoi(auto_eoi), .base_hi(base_hi), .cascade_cfg(cascade_cfg),
        .mask(mask)
    );

    irqc_req #(.W(W)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
        .init_stb(init_stb), .ack_clr(ack_clr), .pend(pend)
    );

    irqc_arb #(.W(W)) u_arb (
        .clk(clk), .rst_n(rst_n), .ready(st_w == ST_READY), .pend(pend),
        .mask(mask), .inta(inta), .eoi_stb(eoi_stb), .init_stb(init_stb),
        .auto_eoi(auto_eoi), .base_hi(base_hi), .int_out(int_out),
        .vec_out(vec_out), .ack_clr(ack_clr), .isr(isr)
    );

    assign rd_data = (rd_en && addr_odd) ? mask : '0;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W),
    localparam int BASE_W = W - IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input init_st_t          st_w,
    input logic              wr_en,
    input logic              addr_odd,
    input logic [W-1:0]      wr_data,
    input logic              inta,
    input logic              int_out,
    input logic [W-1:0]      mask,
    input logic [BASE_W-1:0] base_hi,
    input logic [W-1:0]      vec_out,
    input logic              auto_eoi,
    input logic [W-1:0]      isr,
    input logic              spacing4,
    input logic              nest_en,
    input logic [W-1:0]      cascade_cfg
);
    p_quiet_until_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w != ST_READY) |-> !int_out);

    p_init_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_odd && wr_data[SEL_INIT_BIT]) |=> (st_w == ST_ICW2));

    p_word2_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_odd && st_w == ST_ICW2) |=> (st_w == ST_ICW3));

    p_word4_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_odd && st_w == ST_ICW4) |=> (st_w == ST_READY));

    p_mask_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_odd && st_w != ST_READY) |=> $stable(mask));

    p_vec_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> (vec_out[W-1:IDX_W] == $past(base_hi)));

    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out) |=> (vec_out[IDX_W-1:0] == {IDX_W{1'b1}}));

    p_auto_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        auto_eoi |-> (isr == '0));

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == ST_READY && !(wr_en && !addr_odd)) |=>
            $stable({spacing4, nest_en, cascade_cfg, base_hi}));
endmodule

bind irqc_core irqc_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_w(st_w), .wr_en(wr_en), .addr_odd(addr_odd),
    .wr_data(wr_data), .inta(inta), .int_out(int_out), .mask(mask),
    .base_hi(base_hi), .vec_out(vec_out), .auto_eoi(auto_eoi), .isr(isr),
    .spacing4(spacing4), .nest_en(nest_en), .cascade_cfg(cascade_cfg)
);

// File: tb/tb_irqc_core.sv
module tb_irqc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0, inta = 1'b0;
    logic [7:0] wr_data = '0, irq_in = '0;
    logic [7:0] rd_data, vec_out;
    logic       int_out;
    int         n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    irqc_core dut (
        .clk(clk), .rst_n(rst_n), .addr_odd(addr_odd), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in),
        .int_out(int_out), .inta(inta), .vec_out(vec_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic odd, input logic [7:0] d);
        addr_odd = odd; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; addr_odd = 1'b0;
    endtask

    task automatic rd_mask(output logic [7:0] v);
        addr_odd = 1'b1; rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0; addr_odd = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] w1, w2, w3, w4);
        wr(1'b0, w1); wr(1'b1, w2); wr(1'b1, w3); wr(1'b1, w4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        chk("R1 int_out", {7'b0, int_out}, 8'h00);
        chk("R1 vec_out", vec_out, 8'h00);
        rd_mask(v); chk("R1 mask", v, 8'hFF);

        // R11 odd write ignored before setup
        wr(1'b1, 8'h00);
        rd_mask(v); chk("R11 mask untouched", v, 8'hFF);

        // R2 edge-mode setup; odd writes go to the setup words, not the mask
        setup(8'h11, 8'h45, 8'h04, 8'h01);
        rd_mask(v); chk("R2 mask after setup", v, 8'h00);

        // R4 R6 single-line sweep in edge mode
        for (int n = 0; n < 8; n++) begin
            irq_in[n] = 1'b1;
            edges(2);
            chk("R4 not yet", {7'b0, int_out}, 8'h00);
            edges(1);
            chk("R4 raised", {7'b0, int_out}, 8'h01);
            ack();
            chk("R6 vector", vec_out, 8'(8'h40 + n));
            wr(1'b0, 8'h20);
            edges(2);
            chk("R4 held input no retrigger", {7'b0, int_out}, 8'h00);
            irq_in[n] = 1'b0;
            edges(3);
        end

        // R3 masking
        wr(1'b1, 8'h20);
        irq_in[5] = 1'b1;
        edges(4);
        chk("R3 masked line", {7'b0, int_out}, 8'h00);
        rd_mask(v); chk("R3 readback", v, 8'h20);
        wr(1'b1, 8'h00);
        chk("R3 unmask raises", {7'b0, int_out}, 8'h01);
        ack();
        chk("R3 vector", vec_out, 8'h45);
        wr(1'b0, 8'h20);
        irq_in[5] = 1'b0;
        edges(3);

        // R7 R8 nesting
        irq_in[4] = 1'b1; edges(3); ack();
        chk("R7 first vector", vec_out, 8'h44);
        irq_in[6] = 1'b1; edges(4);
        chk("R7 lower blocked", {7'b0, int_out}, 8'h00);
        irq_in[2] = 1'b1; edges(3);
        chk("R7 higher passes", {7'b0, int_out}, 8'h01);
        ack();
        chk("R7 nested vector", vec_out, 8'h42);
        wr(1'b0, 8'h20);
        chk("R8 line4 still in service", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R8 second eoi frees line6", {7'b0, int_out}, 8'h01);
        ack();
        chk("R8 vector", vec_out, 8'h46);
        wr(1'b0, 8'h20);
        irq_in = '0;
        edges(3);

        // R10 spurious acknowledge
        ack();
        chk("R10 spurious vector", vec_out, 8'h47);
        chk("R10 no request", {7'b0, int_out}, 8'h00);

        // R5 R6 R12 level mode, spacing bit set, exhaustive pair sweep
        setup(8'h1D, 8'h88, 8'h04, 8'h11);
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                irq_in = 8'(1 << a) | 8'(1 << b);
                edges(1);
                chk("R5 not yet", {7'b0, int_out}, 8'h00);
                edges(1);
                chk("R5 raised", {7'b0, int_out}, 8'h01);
                ack();
                chk("R6 R12 pair vector", vec_out, 8'(8'h88 + ((a < b) ? a : b)));
                irq_in = '0;
                edges(2);
                wr(1'b0, 8'h20);
                chk("R5 pending follows level", {7'b0, int_out}, 8'h00);
            end
        end

        // R9 automatic end-of-interrupt
        setup(8'h11, 8'h30, 8'h04, 8'h03);
        irq_in[3] = 1'b1; edges(3);
        chk("R9 raised", {7'b0, int_out}, 8'h01);
        ack();
        chk("R9 vector", vec_out, 8'h33);
        irq_in[5] = 1'b1; edges(3);
        chk("R9 lower raised after auto", {7'b0, int_out}, 8'h01);
        ack();
        chk("R9 lower vector", vec_out, 8'h35);
        irq_in = '0;
        edges(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule